// File: doc/BRIEF.md
# Address-Latched Programmable Byte Memory

This block models a byte-wide memory that is programmed once and then read, with an address holding register built in so that it can share a multiplexed address/data bus without an external latch. A strobe input chooses the address path: while the strobe is high the incoming address flows straight through to the array, and while it is low the value seen on the last clock edge with the strobe high is held. Reads are qualified by two active-low enables; the block presents data one clock after both are low, and a registered valid flag stands in for the tri-state control of a real pin.

A flag that marks the high-voltage identification level on address bit 9 switches the read path from the array to a two-byte identification code, selected by the live value of address bit 0. A simple program port can only clear bits: each program write stores the AND of the old and the new byte, and the synchronous reset plays the role of an erase, returning every bit to one. The depth is a parameter; the full part uses 15 address bits, the default is kept smaller so the array stays light to elaborate.

Top module: `latched_rom`

## Requirements
- R1: When `as_hi` is 1 the array is addressed by `addr` directly and the holding register loads `addr` at the clock edge; when `as_hi` is 0 the array is addressed by the held value and the held value does not change.
- R2: `rd_valid` is 1 in a cycle exactly when `ce_n` and `oe_n` were both 0 at the previous clock edge, and `rd_data` then shows the byte selected at that edge.
- R3: When `ce_n` was 1 at the previous edge, `rd_valid` is 0 whatever `oe_n` was.
- R4: While `rd_valid` is 0, `rd_data` is 8'h00.
- R5: With `id_hv` set and both enables low, the byte returned is 8'h20 when `addr[0]` is 0 and 8'h80 when it is 1, taken from the live `addr[0]` regardless of `as_hi` and of the held address.
- R6: Reset sets every stored byte to 8'hFF and clears `rd_valid` and `rd_data`.
- R7: A program write stores the AND of the stored byte and `wr_data`, so no write changes a 0 into a 1.
- R8: A program write happens at a clock edge where `wr_en` is 1, `ce_n` is 0 and `oe_n` is 1, at the same address a read would use (held or direct per R1).
- R9: A program request with `oe_n` 0 or with `ce_n` 1 leaves the stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array to all ones |
| addr | input | AW | Byte address (AW = 11 by default, 15 for the full part) |
| as_hi | input | 1 | Address strobe: 1 passes the address through, 0 holds it |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| id_hv | input | 1 | High-voltage level present on address bit 9: identification mode |
| wr_en | input | 1 | Program request |
| wr_data | input | 8 | Byte to program (bits at 0 are cleared) |
| rd_data | output | 8 | Read byte, 0 while not valid |
| rd_valid | output | 1 | Registered output-drive qualifier |

## Verification
The bench drops the strobe and moves the address, so a design that forgot to hold the address would return the byte at the new address instead of the held one, and programs through the held address so a write landing on the live address shows up as a corrupted neighbour. It programs the same byte twice with overlapping patterns; a design that overwrote rather than ANDed would return the second pattern. Identification reads toggle bit 0 while the held address has bit 0 set, which catches a design taking the selector from the latch, and program requests made with the output enable low or the chip disabled must leave the byte intact when it is read back. Reset after programming must bring back 8'hFF.

// File: rtl/lrom_pkg.sv
package lrom_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] IDENT_MAKER = 8'h20;
    localparam logic [DW-1:0] IDENT_PART  = 8'h80;
    localparam logic [DW-1:0] ERASED_BYTE = '1;
    localparam logic [DW-1:0] QUIET_BYTE  = '0;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_IDENT = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic id_hv;
        logic wr_en;
    } ctl_t;

    function automatic logic [DW-1:0] ident_byte(input logic sel);
        return sel ? IDENT_PART : IDENT_MAKER;
    endfunction

    function automatic logic [DW-1:0] clear_only(input logic [DW-1:0] old_b,
                                                 input logic [DW-1:0] new_b);
        return old_b & new_b;
    endfunction

    function automatic rd_src_e pick_source(input ctl_t c);
        if (c.ce_n || c.oe_n) return SRC_NONE;
        if (c.id_hv)          return SRC_IDENT;
        return SRC_ARRAY;
    endfunction

    function automatic logic prog_allowed(input ctl_t c);
        return c.wr_en && !c.ce_n && c.oe_n;
    endfunction

endpackage

// File: rtl/lrom_addr_latch.sv
module lrom_addr_latch #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          as_hi,
    output logic [AW-1:0] held,
    output logic [AW-1:0] eff
);
    logic [AW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)        held_q <= '0;
        else if (as_hi) held_q <= addr;
    end

    assign held = held_q;
    assign eff  = as_hi ? addr : held_q;
endmodule

// File: rtl/lrom_cell_array.sv
module lrom_cell_array
    import lrom_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_byte
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED_BYTE;
        end else if (wr_en) begin
            cells[wr_addr] <= clear_only(cells[wr_addr], wr_data);
        end
    end

    assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/lrom_out_stage.sv
module lrom_out_stage
    import lrom_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  rd_src_e       src,
    input  logic [DW-1:0] arr_byte,
    input  logic [DW-1:0] id_byte,
    output logic [DW-1:0] q,
    output logic          q_valid
);
    logic [DW-1:0] nxt;

    always_comb begin
        unique case (src)
            SRC_ARRAY: nxt = arr_byte;
            SRC_IDENT: nxt = id_byte;
            default:   nxt = QUIET_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= QUIET_BYTE;
            q_valid <= 1'b0;
        end else begin
            q       <= nxt;
            q_valid <= (src != SRC_NONE);
        end
    end
endmodule

// File: rtl/latched_rom.sv
module latched_rom
    import lrom_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          as_hi,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          id_hv,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);
    logic [AW-1:0] held_addr;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] arr_byte;
    ctl_t          ctl;
    rd_src_e       src;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, id_hv: id_hv, wr_en: wr_en};
    assign src = pick_source(ctl);

    lrom_addr_latch #(.AW(AW)) u_lat (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .as_hi (as_hi),
        .held  (held_addr),
        .eff   (eff_addr)
    );

    lrom_cell_array #(.AW(AW)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (prog_allowed(ctl)),
        .wr_addr (eff_addr),
        .wr_data (wr_data),
        .rd_addr (eff_addr),
        .rd_byte (arr_byte)
    );

    lrom_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .arr_byte (arr_byte),
        .id_byte  (ident_byte(addr[0])),
        .q        (rd_data),
        .q_valid  (rd_valid)
    );
endmodule

// File: rtl/lrom_chk.sv
module lrom_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          as_hi,
    input logic          ce_n,
    input logic          oe_n,
    input logic          id_hv,
    input logic [7:0]    rd_data,
    input logic          rd_valid,
    input logic [AW-1:0] held_addr
);
    a_r1_hold_when_low: assert property (@(posedge clk) disable iff (rst)
        !$past(as_hi) |-> $stable(held_addr));

    a_r2_valid_needs_enables: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(ce_n) == 1'b0 && $past(oe_n) == 1'b0));

    a_r3_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n) |-> !rd_valid);

    a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == 8'h00);

    a_r5_ident_code: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(id_hv)) |->
            rd_data == ($past(addr[0]) ? 8'h80 : 8'h20));

    logic unused_ok;
    assign unused_ok = &{1'b0, addr[AW-1:1]};
endmodule

bind latched_rom lrom_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .as_hi     (as_hi),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .id_hv     (id_hv),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .held_addr (held_addr)
);

// File: tb/sim_latched_rom.sv
`timescale 1ns/1ps
module sim_latched_rom;
    localparam int AW = 11;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          as_hi = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          id_hv = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'hFF;
    logic [7:0]    rd_data;
    logic          rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    latched_rom #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .as_hi(as_hi), .ce_n(ce_n),
        .oe_n(oe_n), .id_hv(id_hv), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // fields: addr, as_hi, ce_n, oe_n, id_hv, wr_en, wr_data, exp_valid, exp_data, req tag
    localparam logic [32:0] VEC [NV] = '{
        {11'd5, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'hFF}, // 0  R6 erased
        {11'd5, 1'b1,1'b0,1'b1,1'b0,1'b1, 8'hA5, 1'b0, 8'h00}, // 1  R8 program
        {11'd5, 1'b1,1'b0,1'b1,1'b0,1'b1, 8'h3C, 1'b0, 8'h00}, // 2  R7 second program
        {11'd5, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'h24}, // 3  R7 AND result
        {11'd9, 1'b1,1'b0,1'b1,1'b0,1'b1, 8'h0F, 1'b0, 8'h00}, // 4  R8
        {11'd9, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'h0F}, // 5  R1 direct
        {11'd5, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'h0F}, // 6  R1 held
        {11'd5, 1'b0,1'b0,1'b1,1'b0,1'b1, 8'hF0, 1'b0, 8'h00}, // 7  R8 via held addr
        {11'd9, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'h00}, // 8  R8 landed on 9
        {11'd5, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'h24}, // 9  R8 5 untouched
        {11'd5, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'hFF, 1'b0, 8'h00}, // 10 R3 standby
        {11'd5, 1'b1,1'b0,1'b1,1'b0,1'b0, 8'hFF, 1'b0, 8'h00}, // 11 R2 R4 oe high
        {11'd0, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'hFF, 1'b1, 8'h20}, // 12 R5 maker
        {11'd1, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'hFF, 1'b1, 8'h80}, // 13 R5 part
        {11'd1, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'hFF, 1'b0, 8'h00}, // 14 R3 ident standby
        {11'd5, 1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b1, 8'h24}, // 15 R9 oe low write
        {11'd5, 1'b1,1'b1,1'b1,1'b0,1'b1, 8'h00, 1'b0, 8'h00}, // 16 R9 ce high write
        {11'd5, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'hFF, 1'b1, 8'h24}  // 17 R9 still intact
    };

    task automatic check(input string req, input logic v, input logic [7:0] d,
                         input logic ev, input logic [7:0] ed);
        checks++;
        if (v !== ev || d !== ed) begin
            errors++;
            $display("FAIL %s valid=%0b data=%02h expected valid=%0b data=%02h",
                     req, v, d, ev, ed);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset", rd_valid, rd_data, 1'b0, 8'h00);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            {addr, as_hi, ce_n, oe_n, id_hv, wr_en, wr_data} = VEC[i][32:9];
            @(negedge clk);
            check($sformatf("R1/R2/R4/R5/R7/R8/R9 vec%0d", i), rd_valid, rd_data,
                  VEC[i][8], VEC[i][7:0]);
        end
        // erase after programming, R6
        {ce_n, oe_n, wr_en} = 3'b110;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 cleared valid", rd_valid, rd_data, 1'b0, 8'h00);
        {addr, as_hi, ce_n, oe_n, id_hv} = {11'd5, 1'b1, 1'b0, 1'b0, 1'b0};
        @(negedge clk);
        check("R6 erase addr5", rd_valid, rd_data, 1'b1, 8'hFF);
        addr = 11'd9;
        @(negedge clk);
        check("R6 erase addr9", rd_valid, rd_data, 1'b1, 8'hFF);
        // R2: data appears one cycle after enables drop
        ce_n = 1'b1;
        @(negedge clk);
        check("R2 off", rd_valid, rd_data, 1'b0, 8'h00);
        ce_n = 1'b0;
        #1;
        check("R2 not yet", rd_valid, rd_data, 1'b0, 8'h00);
        @(negedge clk);
        check("R2 one cycle later", rd_valid, rd_data, 1'b1, 8'hFF);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule